// File: doc/BRIEF.md
# Prescaled Threshold Timer

A 32-bit interval timer that sits on a simple word-addressed register bus with single-cycle read and write strobes. Software programs a threshold and a control word. While the timer is enabled, a counter advances once per prescaler tick. The tick rate is the core clock divided by one of eight power-of-two divisors. Each time the counter sits at the threshold when a tick arrives, a sticky pending flag is raised. That flag drives the interrupt line directly.

A mode bit picks what happens after a match. In continuous mode the counter restarts from zero, which gives a periodic interrupt. In single-shot mode the counter parks at the threshold and raises no further events until the timer is disabled or the threshold is rewritten. Turning the timer off returns both the counter and the prescaler to zero. The pending flag is cleared by writing a one to a self-clearing bit of the control word.

Top module: `thr_timer`

## Requirements
- R1: After reset the control word, the threshold, the counter and irq_o are all zero.
- R2: Bit 0 of the control word enables the timer. While it is set, the counter starts at zero and advances by one per prescaler tick. The first tick arrives one full divisor period after the write that sets the bit.
- R3: Control bits 3:1 select the divisor. Codes 0..7 give 2, 4, 8, 64, 128, 1024, 2048 and 4096 clocks per tick.
- R4: A tick that finds the counter equal to the threshold is a match event. A match event sets the pending flag, which reads in control bit 31. irq_o equals the pending flag, and the flag stays set until it is cleared.
- R5: With control bit 4 = 1 (continuous), a match event returns the counter to zero, so events repeat every (threshold+1) ticks.
- R6: With control bit 4 = 0 (single-shot), a match event freezes the counter at the threshold. No further match events occur until the timer is disabled or the threshold register is written.
- R7: Writing the control word with bit 30 = 1 clears the pending flag. Writing it with bit 30 = 0 leaves the flag as it is. Bit 30 always reads 0.
- R8: If a match event and a clearing write fall in the same cycle, the pending flag ends up set.
- R9: Clearing the enable bit resets the counter and the prescaler to zero on the following clock.
- R10: The byte offsets are control 0x0, threshold 0x4 (read/write) and counter 0x8 (read-only; writes are ignored). Other offsets read as zero. Control bits 29:5 read as zero. rdata_o is zero while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe, data returned combinationally |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The hardest case to reach is a match event landing in the same cycle as a clearing write. At coarse divisors the two almost never meet. The stimulus therefore sets the threshold to zero, picks the smallest divisor and selects continuous mode, so a match occurs every second clock. It then issues clearing writes on consecutive cycles, which guarantees that some of them coincide with an event. The reference model tracks the counter on every cycle through a read held on the counter offset. This exposes off-by-one errors in the tick timing and in the single-shot freeze.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PSC_W = 12;
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_THRES = 4'h4;
  localparam logic [3:0] OFS_COUNT = 4'h8;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_PSEL = 1;
  localparam int unsigned BIT_MODE = 4;
  localparam int unsigned BIT_CLR  = 30;
  localparam int unsigned BIT_PEND = 31;

  typedef struct packed {
    logic       mode;
    logic [2:0] psel;
    logic       en;
  } ctrl_t;

  // divisor = 2**k, k = 1,2,3,6,7,10,11,12
  function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] sel);
    int unsigned k;
    k = 32'(sel) + 1;
    if (sel >= 3'd3) k = k + 2;
    if (sel >= 3'd5) k = k + 2;
    return PSC_W'((1 << k) - 1);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  thres_o,
  output logic              thres_wr_o,
  output logic              pend_o
);
  logic ctrl_wr;
  logic clr_req;

  assign ctrl_wr    = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign thres_wr_o = wr_en_i && (addr_i == ADDR_W'(OFS_THRES));
  assign clr_req    = ctrl_wr && wdata_i[BIT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      thres_o <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_o.en   <= wdata_i[BIT_EN];
        ctrl_o.psel <= wdata_i[BIT_PSEL +: 3];
        ctrl_o.mode <= wdata_i[BIT_MODE];
      end
      if (thres_wr_o) thres_o <= wdata_i[CNT_W-1:0];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_o <= 1'b0;
    else if (evt_i)   pend_o <= 1'b1;
    else if (clr_req) pend_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] psel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] div_q;

  // >= covers a divisor shrunk while running
  assign tick_o = en_i && (div_q >= psc_last(psel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thres_i,
  input  logic             thres_wr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             halt_o,
  output logic             evt_o
);
  assign evt_o = tick_i && !halt_o && (count_o == thres_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      halt_o  <= 1'b0;
    end else if (!en_i) begin
      count_o <= '0;
      halt_o  <= 1'b0;
    end else begin
      if (evt_o) begin
        if (mode_i) count_o <= '0;
        else        halt_o  <= 1'b1;
      end else if (tick_i && !halt_o) begin
        count_o <= count_o + 1'b1;
      end
      if (thres_wr_i) halt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/thr_timer.sv
module thr_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned RSV_W = DATA_W - 7;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] thres_q;
  logic [CNT_W-1:0] count_q;
  logic             thres_wr;
  logic             pend_q;
  logic             tick;
  logic             match_evt;
  logic             halt_q;
  logic             en_q;
  logic [DATA_W-1:0] rd_mux;

  assign en_q = ctrl_q.en;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .evt_i(match_evt), .ctrl_o(ctrl_q), .thres_o(thres_q),
    .thres_wr_o(thres_wr), .pend_o(pend_q)
  );

  tmr_prescaler u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .psel_i(ctrl_q.psel),
    .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .mode_i(ctrl_q.mode),
    .tick_i(tick), .thres_i(thres_q), .thres_wr_i(thres_wr),
    .count_o(count_q), .halt_o(halt_q), .evt_o(match_evt)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_CTRL):  rd_mux = {pend_q, 1'b0, {RSV_W{1'b0}},
                                    ctrl_q.mode, ctrl_q.psel, ctrl_q.en};
      ADDR_W'(OFS_THRES): rd_mux = DATA_W'(thres_q);
      ADDR_W'(OFS_COUNT): rd_mux = DATA_W'(count_q);
      default:            rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_en_i ? rd_mux : '0;
  assign irq_o   = pend_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wclr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              en_i,
  input logic              tick_i,
  input logic              evt_i,
  input logic              halt_i,
  input logic [CNT_W-1:0]  count_i
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL)) && wclr_i;

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_wr |=> irq_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !evt_i |=> !irq_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> irq_o);
  p_off_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> count_i == '0);
  p_no_tick_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> count_i == $past(count_i));
  p_tick_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> en_i);
  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && halt_i |=> count_i == $past(count_i));
  p_rsv_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(OFS_CTRL) |-> rdata_o[DATA_W-2:5] == '0);
  p_idle_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

bind thr_timer tmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wclr_i(wdata_i[30]), .rdata_o(rdata_o), .irq_o(irq_o),
  .en_i(en_q), .tick_i(tick), .evt_i(match_evt), .halt_i(halt_q),
  .count_i(count_q)
);

// File: tb/tb_thr_timer.sv
module tb_thr_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = 4'h8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  thr_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model state
  bit        m_en, m_mode, m_halt, m_pend;
  bit [2:0]  m_psel;
  bit [31:0] m_thres, m_count;
  int        m_pc;

  function automatic int divisor(bit [2:0] s);
    case (s)
      3'd0: return 2;    3'd1: return 4;    3'd2: return 8;    3'd3: return 64;
      3'd4: return 128;  3'd5: return 1024; 3'd6: return 2048; default: return 4096;
    endcase
  endfunction

  function automatic bit [31:0] m_read(bit re, bit [3:0] a);
    if (!re) return 32'h0;
    case (a)
      4'h0: return {m_pend, 26'h0, m_mode, m_psel, m_en};
      4'h4: return m_thres;
      4'h8: return m_count;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_halt = 0; m_pend = 0; m_psel = 0;
      m_thres = 0; m_count = 0; m_pc = 0;
    end else begin
      bit tick, evt, cwr, twr;
      tick = m_en && (m_pc >= divisor(m_psel) - 1);
      evt  = tick && !m_halt && (m_count == m_thres);
      cwr  = wr_en && addr == 4'h0;
      twr  = wr_en && addr == 4'h4;
      if (evt) m_pend = 1;
      else if (cwr && wdata[30]) m_pend = 0;
      if (!m_en) begin
        m_pc = 0; m_count = 0; m_halt = 0;
      end else begin
        m_pc = tick ? 0 : m_pc + 1;
        if (evt) begin
          if (m_mode) m_count = 0; else m_halt = 1;
        end else if (tick && !m_halt) m_count = m_count + 1;
        if (twr) m_halt = 0;
      end
      if (cwr) begin
        m_en = wdata[0]; m_psel = wdata[3:1]; m_mode = wdata[4];
      end
      if (twr) m_thres = wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // compare after every edge, before inputs move at negedge
  always begin
    @(posedge clk);
    #3;
    if (rst_n) begin
      chk({cur_tag, " R4 irq"}, {31'h0, irq}, {31'h0, m_pend});
      chk({cur_tag, " R10 rdata"}, rdata, m_read(rd_en, addr));
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 0; rd_en = 1; addr = 4'h8;
    end
  endtask

  task automatic wr(bit [3:0] a, bit [31:0] d);
    @(negedge clk);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 1; addr = 4'h8;
  endtask

  task automatic rd(bit [3:0] a);
    @(negedge clk);
    wr_en = 0; rd_en = 1; addr = a;
    @(negedge clk);
    addr = 4'h8;
  endtask

  initial begin
    #(160000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    cur_tag = "R1";
    @(negedge clk);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(4'h0); rd(4'h4); rd(4'h8);

    // R10: map, read-only counter, unused offsets, idle bus
    cur_tag = "R10";
    wr(4'h8, 32'h0000_1234);
    rd(4'h8); rd(4'hC); rd(4'h2);
    wr(4'h4, 32'hDEAD_BEEF);
    rd(4'h4);
    @(negedge clk); rd_en = 0;
    @(negedge clk);
    chk("R10 idle bus", rdata, 32'h0);

    // R2/R5: divisor 2, continuous, threshold 3
    cur_tag = "R2 R5";
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h0000_0011);
    idle(40);
    // R7: writing 0 to bit 30 keeps the flag, writing 1 clears it
    cur_tag = "R7";
    wr(4'h0, 32'h0000_0011);
    wr(4'h0, 32'h4000_0011);
    idle(3);
    rd(4'h0);
    wr(4'h0, 32'h0);

    // R3: divisor sweep
    cur_tag = "R3";
    for (int c = 1; c < 8; c++) begin
      int d;
      d = divisor(3'(c));
      wr(4'h4, (c < 5) ? 32'd2 : 32'd0);
      wr(4'h0, 32'h4000_0011 | (32'(c) << 1));
      idle((c < 5) ? 3 * d + 6 : d + 6);
      wr(4'h0, 32'h4000_0000);
    end

    // R6: single-shot freeze and release by threshold write
    cur_tag = "R6";
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h0000_0001);
    idle(30);
    wr(4'h0, 32'h4000_0001);
    idle(20);
    wr(4'h4, 32'd8);
    idle(30);

    // R9: disable mid-run clears counter, re-enable restarts prescaler
    cur_tag = "R9";
    wr(4'h4, 32'd200);
    wr(4'h0, 32'h4000_0005);
    idle(37);
    wr(4'h0, 32'h0);
    idle(4);
    wr(4'h0, 32'h0000_0005);
    idle(20);

    // R8: match every second clock against back-to-back clears
    cur_tag = "R8";
    wr(4'h4, 32'd0);
    wr(4'h0, 32'h0000_0011);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1; rd_en = 1; addr = 4'h0; wdata = 32'h4000_0011;
    end
    idle(6);

    // R10: reserved bits and bit 30 read zero after all-ones write
    cur_tag = "R10 R7";
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0);
    wr(4'h0, 32'h4000_0000);
    rd(4'h0);
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule